// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits between a serial-bus protocol engine and a 256-byte storage array. During one write transaction it collects the incoming data bytes into a 16-byte page buffer, with a valid bit for each slot. The slot is chosen by the low four bits of a byte pointer. That pointer is loaded at the start of the transaction, and its upper four bits select the page. Bytes go into the array only when the transaction closes with a Stop. Any other ending leaves the array alone.

After a Stop that follows at least one data byte, the block runs a self-timed write cycle of `CYCLE_CLKS` clocks, with `busy_o` raised for the protocol engine. In the first 16 clocks of that cycle it scans the buffer slots in order and drives one array write for each valid slot. A write-protect input that is high at the Stop blocks every array write, but the busy period still runs in full. While busy, the block ignores all transaction inputs. The protocol engine uses `busy_o` to withhold acknowledges. The array write port is a plain write-enable, address and data interface. The bench connects it to a behavioural memory.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset `busy_o` and `mem_we_o` are 0 and `ptr_o` is 8'h00.
- R2: `txn_start_i` loads `ptr_o` with `addr_i`. Each accepted data byte adds one to `ptr_o[3:0]` modulo 16, and `ptr_o[7:4]` does not change. Writing past offset 15 therefore wraps to offset 0 of the same page.
- R3: A byte is stored at page slot `ptr_o[3:0]`. When more than 16 bytes arrive, later bytes overwrite earlier ones in arrival order, so the array receives the last byte sent for each slot.
- R4: No array write happens before the Stop. Every `mem_we_o` pulse lies inside a cycle where `busy_o` is 1.
- R5: A Stop with at least one buffered byte makes `busy_o` go high on the next clock. It stays high for exactly `CYCLE_CLKS` clocks.
- R6: Only slots written in the current transaction are committed. A single-byte transaction makes exactly one array write, and the other locations keep their contents.
- R7: If `wp_i` is high when the Stop is accepted, no array location changes, but `busy_o` still lasts `CYCLE_CLKS` clocks.
- R8: `abort_i` (an abort or a repeated Start) discards the buffered bytes without any write or busy period. `ptr_o` keeps its value, and a later Stop commits nothing.
- R9: A Stop with no buffered bytes causes no busy period and no array write.
- R10: While `busy_o` is 1, the inputs `txn_start_i`, `byte_vld_i`, `stop_i` and `abort_i` have no effect on `ptr_o`, the buffer or the busy length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txn_start_i | input | 1 | Start of write transaction: load pointer, clear buffer |
| addr_i | input | 8 | Start address loaded by `txn_start_i` |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop strobe ending the transaction |
| abort_i | input | 1 | Abort or repeated Start: discard buffer |
| wp_i | input | 1 | Write protect, high blocks array writes |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 8 | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| busy_o | output | 1 | Internal write cycle in progress |
| ptr_o | output | 8 | Current byte pointer |

## Verification
The assertions assume that each strobe is a single-clock pulse and that at most one of start, byte, stop and abort is high in any clock. They also assume that `CYCLE_CLKS` is at least 16, so the slot scan ends inside the busy window. The bench drives every strobe as a one-clock pulse from its tasks, never overlaps them, and uses a cycle length of 40. The only deliberate breach of idle-only stimulus is the scenario for R10, which pulses all four strobes while the block is busy.

// File: rtl/page_pkg.sv
package page_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int PAGE_W = 4;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [PAGE_W-1:0] slot_t;

  typedef struct packed {
    logic  vld;
    slot_t idx;
    data_t data;
  } slot_wr_t;
endpackage

// File: rtl/page_pointer.sv
module page_pointer
  import page_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  addr_t load_addr_i,
  input  logic  inc_i,
  output addr_t ptr_o
);
  localparam int HI_W = ADDR_W - PAGE_W;

  addr_t ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (load_i) begin
      ptr_q <= load_addr_i;
    end else if (inc_i) begin
      // page bits held, column wraps inside the page
      ptr_q <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + slot_t'(1)};
    end
  end

  assign ptr_o = ptr_q;

  assert_page_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W]));

  assert_col_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> ptr_q[PAGE_W-1:0] == slot_t'($past(ptr_q[PAGE_W-1:0]) + 1'b1));

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = ptr_q[ADDR_W-1:PAGE_W];
endmodule

// File: rtl/page_buffer.sv
module page_buffer
  import page_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clear_i,
  input  slot_wr_t wr_i,
  input  slot_t    rd_idx_i,
  output data_t    rd_data_o,
  output logic     rd_vld_o,
  output logic     any_vld_o
);
  data_t                 data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g] <= '0;
      end else if (wr_i.vld && wr_i.idx == slot_t'(g)) begin
        data_q[g] <= wr_i.data;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[g] <= 1'b0;
      end else if (clear_i) begin
        mask_q[g] <= 1'b0;
      end else if (wr_i.vld && wr_i.idx == slot_t'(g)) begin
        mask_q[g] <= 1'b1;
      end
    end
  end

  assign rd_data_o = data_q[rd_idx_i];
  assign rd_vld_o  = mask_q[rd_idx_i];
  assign any_vld_o = |mask_q;

  assert_clear_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> mask_q == '0);

  assert_one_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i.vld && !clear_i) |=> $countones(mask_q ^ $past(mask_q)) <= 1);
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import page_pkg::*;
#(
  parameter int CYCLE_CLKS = 500000
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  output logic  busy_o,
  output logic  done_o,
  output slot_t slot_o,
  output logic  slot_vld_o
);
  localparam int CNT_W  = $clog2(CYCLE_CLKS + 1);
  localparam int SCAN_W = PAGE_W + 1;

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SCAN_W-1:0] scan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      scan_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(CYCLE_CLKS - 1);
        scan_q <= '0;
      end
    end else begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (scan_q != SCAN_W'(PAGE_BYTES)) begin
        scan_q <= scan_q + 1'b1;
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = busy_q && (cnt_q == '0);
  assign slot_o     = scan_q[PAGE_W-1:0];
  assign slot_vld_o = busy_q && (scan_q < SCAN_W'(PAGE_BYTES));

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q < CNT_W'(CYCLE_CLKS));

  assert_start_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> busy_q && cnt_q == CNT_W'(CYCLE_CLKS - 1));

  assert_count_down_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q && cnt_q == $past(cnt_q) - 1'b1);

  assert_scan_in_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_vld_o |-> busy_q);
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
  import page_pkg::*;
#(
  parameter int CYCLE_CLKS = 500000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       txn_start_i,
  input  logic [7:0] addr_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       stop_i,
  input  logic       abort_i,
  input  logic       wp_i,
  output logic       mem_we_o,
  output logic [7:0] mem_addr_o,
  output logic [7:0] mem_wdata_o,
  output logic       busy_o,
  output logic [7:0] ptr_o
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic            busy;
  logic            done;
  logic            idle;
  logic            take_start;
  logic            take_byte;
  logic            take_abort;
  logic            commit;
  logic            buf_clear;
  logic            any_vld;
  logic            slot_vld;
  logic            rd_vld;
  slot_t           scan_slot;
  data_t           rd_data;
  addr_t           ptr;
  slot_wr_t        wr_req;
  logic            wp_q;
  logic [HI_W-1:0] page_q;

  assign idle       = !busy;
  assign take_abort = idle && abort_i;
  assign take_start = idle && !abort_i && txn_start_i;
  assign take_byte  = idle && !abort_i && !txn_start_i && byte_vld_i;
  assign commit     = idle && !abort_i && !txn_start_i && stop_i && any_vld;
  assign buf_clear  = take_abort || take_start || done;

  assign wr_req.vld  = take_byte;
  assign wr_req.idx  = ptr[PAGE_W-1:0];
  assign wr_req.data = byte_i;

  page_pointer u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (take_start),
    .load_addr_i (addr_i),
    .inc_i       (take_byte),
    .ptr_o       (ptr)
  );

  page_buffer u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (buf_clear),
    .wr_i      (wr_req),
    .rd_idx_i  (scan_slot),
    .rd_data_o (rd_data),
    .rd_vld_o  (rd_vld),
    .any_vld_o (any_vld)
  );

  cycle_timer #(
    .CYCLE_CLKS (CYCLE_CLKS)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (commit),
    .busy_o     (busy),
    .done_o     (done),
    .slot_o     (scan_slot),
    .slot_vld_o (slot_vld)
  );

  // page and protect are frozen at the Stop for the whole cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= 1'b0;
      page_q <= '0;
    end else if (commit) begin
      wp_q   <= wp_i;
      page_q <= ptr[ADDR_W-1:PAGE_W];
    end
  end

  assign mem_we_o    = slot_vld && rd_vld && !wp_q;
  assign mem_addr_o  = {page_q, scan_slot};
  assign mem_wdata_o = rd_data;
  assign busy_o      = busy;
  assign ptr_o       = ptr;

  assert_we_in_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  assert_wp_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wp_q) |-> !mem_we_o);

  assert_stop_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> busy_o);

  assert_ptr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(ptr_o));

  assert_abort_no_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && abort_i) |=> !busy_o);

  assert_empty_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && stop_i && !any_vld) |=> !busy_o);

  assert_page_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:PAGE_W]));
endmodule

// File: tb/tb_page_commit_ctrl.sv
module tb_page_commit_ctrl;
  localparam int CYC = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txn_start = 1'b0;
  logic [7:0] addr = '0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_d = '0;
  logic       stop = 1'b0;
  logic       abort = 1'b0;
  logic       wp = 1'b0;
  logic       mem_we;
  logic [7:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       busy;
  logic [7:0] ptr;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int stray = 0;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];

  always #5 clk = ~clk;

  page_commit_ctrl #(.CYCLE_CLKS(CYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .txn_start_i(txn_start), .addr_i(addr),
    .byte_vld_i(byte_vld), .byte_i(byte_d), .stop_i(stop), .abort_i(abort),
    .wp_i(wp), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .busy_o(busy), .ptr_o(ptr)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
      if (!busy) stray <= stray + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_mem(input string req);
    int bad = -1;
    for (int i = 0; i < 256; i++)
      if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, {req, " mem"}, int'(mem[bad]), int'(exp_mem[bad]));
  endtask

  task automatic do_start(input logic [7:0] a);
    @(negedge clk); txn_start = 1'b1; addr = a;
    @(negedge clk); txn_start = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] d);
    @(negedge clk); byte_vld = 1'b1; byte_d = d;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic do_abort();
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
  endtask

  // pulse stop, return number of busy cycles seen
  task automatic do_stop(output int n);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    n = 0;
    while (busy && n < 4 * CYC) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(mem_we == 1'b0, "R1 we", int'(mem_we), 0);
    check(ptr == 8'h00, "R1 ptr", int'(ptr), 0);
  endtask

  task automatic t_single();
    int n;
    int w0;
    do_start(8'h25);
    do_byte(8'h5A);
    check(ptr == 8'h26, "R2 ptr after one byte", int'(ptr), 8'h26);
    check_mem("R4 no write before stop");
    w0 = wr_cnt;
    do_stop(n);
    exp_mem[8'h25] = 8'h5A;
    check(n == CYC, "R5 busy length", n, CYC);
    check(wr_cnt - w0 == 1, "R6 single write count", wr_cnt - w0, 1);
    check_mem("R6 single byte");
  endtask

  task automatic t_page_wrap();
    int n;
    do_start(8'h3C);
    for (int i = 0; i < 6; i++) do_byte(8'hA0 + 8'(i));
    check(ptr == 8'h32, "R2 ptr wraps in page", int'(ptr), 8'h32);
    do_stop(n);
    for (int i = 0; i < 6; i++) exp_mem[{4'h3, 4'(4'hC + i)}] = 8'hA0 + 8'(i);
    check(n == CYC, "R5 busy length page", n, CYC);
    check_mem("R2 page wrap");
  endtask

  task automatic t_overflow();
    int n;
    do_start(8'h50);
    for (int i = 0; i < 20; i++) do_byte(8'hC0 + 8'(i));
    check(ptr == 8'h54, "R3 ptr after 20 bytes", int'(ptr), 8'h54);
    do_stop(n);
    for (int i = 0; i < 20; i++) exp_mem[8'h50 + 8'(i % 16)] = 8'hC0 + 8'(i);
    check_mem("R3 last sixteen kept");
  endtask

  task automatic t_wp();
    int n;
    int w0;
    wp = 1'b1;
    do_start(8'h90);
    for (int i = 0; i < 4; i++) do_byte(8'h11 * 8'(i + 1));
    w0 = wr_cnt;
    do_stop(n);
    wp = 1'b0;
    check(n == CYC, "R7 busy length protected", n, CYC);
    check(wr_cnt == w0, "R7 no writes", wr_cnt - w0, 0);
    check_mem("R7 array unchanged");
  endtask

  task automatic t_abort();
    int n;
    do_start(8'h10);
    for (int i = 0; i < 3; i++) do_byte(8'h77);
    do_abort();
    check(busy == 1'b0, "R8 no busy on abort", int'(busy), 0);
    check(ptr == 8'h13, "R8 ptr kept", int'(ptr), 8'h13);
    do_stop(n);
    check(n == 0, "R8 stop after abort", n, 0);
    check_mem("R8 nothing committed");
  endtask

  task automatic t_empty_stop();
    int n;
    do_start(8'h77);
    do_stop(n);
    check(n == 0, "R9 empty stop no busy", n, 0);
    check(ptr == 8'h77, "R9 ptr", int'(ptr), 8'h77);
    check_mem("R9 no write");
  endtask

  task automatic t_busy_ignore();
    int n;
    do_start(8'hE0);
    do_byte(8'h3E);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    n = 1;
    txn_start = 1'b1; addr = 8'h80;
    @(negedge clk); n++; txn_start = 1'b0; byte_vld = 1'b1; byte_d = 8'hFF;
    @(negedge clk); n++; byte_vld = 1'b0; abort = 1'b1;
    @(negedge clk); n++; abort = 1'b0; stop = 1'b1;
    @(negedge clk); n++; stop = 1'b0;
    while (busy && n < 4 * CYC) begin
      n++;
      @(negedge clk);
    end
    n--;
    exp_mem[8'hE0] = 8'h3E;
    check(n == CYC, "R10 busy length unchanged", n, CYC);
    check(ptr == 8'hE1, "R10 ptr unchanged", int'(ptr), 8'hE1);
    check_mem("R10 inputs ignored");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'hA5;
      exp_mem[i] = 8'(i) ^ 8'hA5;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_page_wrap();
    t_overflow();
    t_wp();
    t_abort();
    t_empty_stop();
    t_busy_ignore();
    check(stray == 0, "R4 writes outside busy", stray, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule